// File: doc/BRIEF.md
# Remote Operand Buffer with Stack-Pointer Retention

In a clustered out-of-order core, each cluster keeps a small buffer for source operands whose producers live in another cluster's physical register file. A dispatching instruction that needs such an operand allocates an entry keyed by the physical register tag. When the producer completes, its result is captured in that entry in the same cycle as the register-file write, so local consumers read the value without a second remote access.

The buffer has two pools. The general pool (default four entries) holds ordinary operands, and an entry is freed when its single consumer reads it. A separate two-entry reserved pool holds stack-pointer definitions. These entries are filled eagerly at completion and survive any number of reads. Each one is released only when a newer stack-pointer definition commits. A lookup that misses both pools raises a request to the remote register file, and the remote data is presented one cycle later. A flush drops all speculative state but keeps the committed stack-pointer value.

Top module: `remote_operand_buf`

## Requirements
- R1: A lookup that matches a valid entry whose result has arrived returns hit=1, ready=1 and the stored data in the same cycle.
- R2: A lookup that matches a valid entry still waiting for its result returns hit=1, ready=0 and all-zero data.
- R3: A lookup that matches no entry raises the remote request in the same cycle, with the looked-up tag on the request tag output. In the next cycle the remote-valid output is 1 and the remote-data output carries the remote-data input of that cycle. Otherwise the remote-valid output is 0.
- R4: A result write whose tag matches a valid entry in either pool marks that entry ready and stores the data at the clock edge of the write. A lookup in the following cycle sees the new value.
- R5: A general-pool entry is freed at the edge of the cycle in which a lookup reads it while ready. A later lookup of that tag misses.
- R6: A stack-pointer entry stays valid across any number of ready lookups.
- R7: Committing a stack-pointer tag marks that entry committed and releases any other stack-pointer entry committed earlier. No other event releases a stack-pointer entry except flush and reset.
- R8: The general pool holds GP_DEPTH entries (default 4) and the stack-pointer pool holds SP_DEPTH entries (default 2), kept separate; alloc_sp_i=1 selects the stack-pointer pool. stall_o is 1 exactly when an allocation is requested and the selected pool has no free slot, and such an allocation is refused.
- R9: A slot released in a cycle counts as free for an allocation in that same cycle, so the allocation is accepted (stall_o=0) and lands in the released slot.
- R10: A flush clears every general-pool entry and every uncommitted stack-pointer entry, keeps the committed stack-pointer entry and its data, and discards an allocation requested in the same cycle.
- R11: An asynchronous active-low reset empties both pools, and while it is asserted every output is 0 when the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_sp_i | input | 1 | Allocation is a stack-pointer definition |
| alloc_tag_i | input | TAG_W | Physical register tag to allocate |
| stall_o | output | 1 | Selected pool full, allocation refused |
| wr_valid_i | input | 1 | Completing result write |
| wr_tag_i | input | TAG_W | Tag of the completing result |
| wr_data_i | input | DATA_W | Result data |
| lk_valid_i | input | 1 | Lookup request |
| lk_tag_i | input | TAG_W | Tag to look up |
| lk_hit_o | output | 1 | Lookup matched an entry |
| lk_ready_o | output | 1 | Matched entry holds its result |
| lk_data_o | output | DATA_W | Data of a ready hit, zero otherwise |
| rem_req_o | output | 1 | Remote register-file read request on a miss |
| rem_tag_o | output | TAG_W | Tag for the remote read |
| rem_data_i | input | DATA_W | Remote register-file data, one cycle after the request |
| rem_valid_o | output | 1 | Remote operand delivered this cycle |
| rem_data_o | output | DATA_W | Remote operand, zero when not valid |
| sp_commit_i | input | 1 | A stack-pointer definition commits |
| sp_commit_tag_i | input | TAG_W | Tag of the committing stack-pointer definition |
| flush_i | input | 1 | Discard speculative entries |

## Verification
On every cycle the assertions check four things: a ready general-pool read frees its slot, reads never drop a stack-pointer entry, at most one committed stack-pointer entry exists, and a flush empties the general pool. They also check that a miss delivers a remote operand in the next cycle, that an unready hit carries no data and that no allocation enters a full pool. The bench's scenarios are needed for the rest. Those are the release of the older stack-pointer entry on the next commit, reuse of a slot freed in the same cycle, the survival of the committed value across a flush with a same-cycle allocation dropped, and the exact data and tags returned.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic {
    POOL_GP = 1'b0,
    POOL_SP = 1'b1
  } pool_kind_e;
endpackage

// File: rtl/rop_pool.sv
module rop_pool
  import rop_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter pool_kind_e  KIND   = POOL_GP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_en_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  output logic              full_o,
  input  logic              wr_valid_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lk_valid_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              commit_i,
  input  logic [TAG_W-1:0]  commit_tag_i,
  input  logic              flush_i
);
  localparam bit IS_SP = (KIND == POOL_SP);

  logic [DEPTH-1:0]  vld_q, rdy_q, cmt_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];

  logic [DEPTH-1:0] hit_vec, cmt_hit, wr_hit, rel, free_vec, pick;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = lk_valid_i && vld_q[i] && (tag_q[i] == lk_tag_i);
      cmt_hit[i] = IS_SP && commit_i && vld_q[i] && (tag_q[i] == commit_tag_i);
      wr_hit[i]  = wr_valid_i && vld_q[i] && (tag_q[i] == wr_tag_i);
    end
  end

  // sp: older committed entry released by a newer commit; gp: freed by ready read
  assign rel = IS_SP ? ((|cmt_hit) ? (cmt_q & vld_q & ~cmt_hit) : '0)
                     : (hit_vec & rdy_q);

  // release before allocate: released slots are free this cycle
  assign free_vec = ~vld_q | rel;
  assign full_o   = ~|free_vec;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_vec[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    hit_o   = |hit_vec;
    ready_o = |(hit_vec & rdy_q);
    data_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i] && rdy_q[i]) data_o = data_o | dat_q[i];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              v_q, r_q, c_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              keep, cmt_n;

    assign keep  = v_q & ~rel[i];
    assign cmt_n = (c_q & keep) | cmt_hit[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        c_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else if (alloc_en_i && pick[i]) begin
        v_q <= 1'b1;
        r_q <= 1'b0;
        c_q <= 1'b0;
        t_q <= alloc_tag_i;
      end else begin
        v_q <= keep & (~flush_i | cmt_n);
        c_q <= cmt_n;
        if (wr_hit[i]) begin
          r_q <= 1'b1;
          d_q <= wr_data_i;
        end
      end
    end

    assign vld_q[i] = v_q;
    assign rdy_q[i] = r_q;
    assign cmt_q[i] = c_q;
    assign tag_q[i] = t_q;
    assign dat_q[i] = d_q;

    if (IS_SP) begin : g_sp_chk
      assert_sp_read_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_vec[i] && !commit_i && !flush_i) |=> v_q);
    end else begin : g_gp_chk
      assert_gp_read_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_vec[i] && r_q && !(alloc_en_i && pick[i])) |=> !v_q);
    end
  end

  assert_no_alloc_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> !full_o);

  assert_single_committed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmt_q & vld_q) <= 1);

  assert_flush_empties_gp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_SP && flush_i && !alloc_en_i) |=> (vld_q == '0));
endmodule

// File: rtl/remote_operand_buf.sv
module remote_operand_buf
  import rop_pkg::*;
#(
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GP_DEPTH = 4,
  parameter int unsigned SP_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic              alloc_sp_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  output logic              stall_o,
  input  logic              wr_valid_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lk_valid_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic              lk_ready_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic              rem_req_o,
  output logic [TAG_W-1:0]  rem_tag_o,
  input  logic [DATA_W-1:0] rem_data_i,
  output logic              rem_valid_o,
  output logic [DATA_W-1:0] rem_data_o,
  input  logic              sp_commit_i,
  input  logic [TAG_W-1:0]  sp_commit_tag_i,
  input  logic              flush_i
);
  logic gp_full, sp_full, gp_alloc, sp_alloc;
  logic gp_hit, sp_hit, gp_rdy, sp_rdy;
  logic [DATA_W-1:0] gp_dat, sp_dat;
  logic rem_q;

  assign gp_alloc = alloc_valid_i & ~alloc_sp_i & ~flush_i & ~gp_full;
  assign sp_alloc = alloc_valid_i &  alloc_sp_i & ~flush_i & ~sp_full;
  assign stall_o  = alloc_valid_i & (alloc_sp_i ? sp_full : gp_full);

  rop_pool #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(GP_DEPTH), .KIND(POOL_GP)
  ) i_gp_pool (
    .clk_i, .rst_ni,
    .alloc_en_i(gp_alloc), .alloc_tag_i, .full_o(gp_full),
    .wr_valid_i, .wr_tag_i, .wr_data_i,
    .lk_valid_i, .lk_tag_i,
    .hit_o(gp_hit), .ready_o(gp_rdy), .data_o(gp_dat),
    .commit_i(sp_commit_i), .commit_tag_i(sp_commit_tag_i),
    .flush_i
  );

  rop_pool #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(SP_DEPTH), .KIND(POOL_SP)
  ) i_sp_pool (
    .clk_i, .rst_ni,
    .alloc_en_i(sp_alloc), .alloc_tag_i, .full_o(sp_full),
    .wr_valid_i, .wr_tag_i, .wr_data_i,
    .lk_valid_i, .lk_tag_i,
    .hit_o(sp_hit), .ready_o(sp_rdy), .data_o(sp_dat),
    .commit_i(sp_commit_i), .commit_tag_i(sp_commit_tag_i),
    .flush_i
  );

  assign lk_hit_o   = gp_hit | sp_hit;
  assign lk_ready_o = gp_rdy | sp_rdy;
  assign lk_data_o  = gp_dat | sp_dat;

  // miss goes to the remote file; one-cycle penalty
  assign rem_req_o = lk_valid_i & ~lk_hit_o;
  assign rem_tag_o = lk_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= 1'b0;
    else         rem_q <= rem_req_o;
  end

  assign rem_valid_o = rem_q;
  assign rem_data_o  = rem_q ? rem_data_i : '0;

  assert_miss_delivers_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_hit_o) |=> rem_valid_o);

  assert_unready_no_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !lk_ready_o) |-> (lk_data_o == '0));
endmodule

// File: tb/test_remote_operand_buf.sv
`timescale 1ns/1ps
module test_remote_operand_buf;
  localparam int TAG_W = 6;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [3:0] rq;
    logic av, asp; logic [5:0] atag;
    logic wv; logic [5:0] wtag; logic [7:0] wd;
    logic lv; logic [5:0] ltag;
    logic cm; logic [5:0] ctag;
    logic fl;
    logic es, eh, er; logic [7:0] ed; logic eq, erv;
  } vec_t;

  function automatic vec_t v(int rq, int av, int asp, int atag, int wv, int wtag, int wd,
                             int lv, int ltag, int cm, int ctag, int fl,
                             int es, int eh, int er, int ed, int eq, int erv);
    vec_t r;
    r.rq = 4'(rq); r.av = 1'(av); r.asp = 1'(asp); r.atag = 6'(atag);
    r.wv = 1'(wv); r.wtag = 6'(wtag); r.wd = 8'(wd);
    r.lv = 1'(lv); r.ltag = 6'(ltag); r.cm = 1'(cm); r.ctag = 6'(ctag); r.fl = 1'(fl);
    r.es = 1'(es); r.eh = 1'(eh); r.er = 1'(er); r.ed = 8'(ed); r.eq = 1'(eq); r.erv = 1'(erv);
    return r;
  endfunction

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    v(8, 1,0,10, 0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),     // R8 gp alloc
    v(2, 0,0,0,  0,0,0,     1,10, 0,0, 0,  0,1,0,0,0,0),     // R2 pending
    v(4, 0,0,0,  1,10,'h11, 1,10, 0,0, 0,  0,1,0,0,0,0),     // R4 write lands at edge
    v(1, 0,0,0,  0,0,0,     1,10, 0,0, 0,  0,1,1,'h11,0,0),  // R1 ready read
    v(5, 0,0,0,  0,0,0,     1,10, 0,0, 0,  0,0,0,0,1,0),     // R5 freed
    v(3, 0,0,0,  0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,1),     // R3 remote next cycle
    v(8, 1,1,20, 0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),
    v(4, 0,0,0,  1,20,'h22, 0,0,  0,0, 0,  0,0,0,0,0,0),
    v(6, 0,0,0,  0,0,0,     1,20, 0,0, 0,  0,1,1,'h22,0,0),  // R6
    v(6, 0,0,0,  0,0,0,     1,20, 0,0, 0,  0,1,1,'h22,0,0),
    v(6, 0,0,0,  0,0,0,     1,20, 0,0, 0,  0,1,1,'h22,0,0),
    v(7, 0,0,0,  0,0,0,     1,20, 1,20,0,  0,1,1,'h22,0,0),  // R7 first commit
    v(7, 0,0,0,  0,0,0,     1,20, 0,0, 0,  0,1,1,'h22,0,0),
    v(8, 1,1,21, 0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),
    v(8, 1,1,22, 0,0,0,     0,0,  0,0, 0,  1,0,0,0,0,0),     // R8 sp full
    v(4, 0,0,0,  1,21,'h33, 0,0,  0,0, 0,  0,0,0,0,0,0),
    v(7, 0,0,0,  0,0,0,     1,20, 1,21,0,  0,1,1,'h22,0,0),  // R7 newer commit
    v(7, 0,0,0,  0,0,0,     1,20, 0,0, 0,  0,0,0,0,1,0),     // R7 older released
    v(8, 1,1,22, 0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,1),
    v(8, 1,0,1,  0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),
    v(8, 1,0,2,  0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),
    v(8, 1,0,3,  0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),
    v(8, 1,0,4,  0,0,0,     0,0,  0,0, 0,  0,0,0,0,0,0),
    v(8, 1,0,5,  0,0,0,     0,0,  0,0, 0,  1,0,0,0,0,0),     // R8 gp full
    v(4, 0,0,0,  1,1,'h44,  0,0,  0,0, 0,  0,0,0,0,0,0),
    v(9, 1,0,5,  0,0,0,     1,1,  0,0, 0,  0,1,1,'h44,0,0),  // R9 reuse
    v(9, 0,0,0,  0,0,0,     1,5,  0,0, 0,  0,1,0,0,0,0),
    v(10,0,0,0,  0,0,0,     0,0,  0,0, 1,  0,0,0,0,0,0),     // R10 flush
    v(10,0,0,0,  0,0,0,     1,5,  0,0, 0,  0,0,0,0,1,0),
    v(10,0,0,0,  0,0,0,     1,21, 0,0, 0,  0,1,1,'h33,0,1),
    v(10,0,0,0,  0,0,0,     1,22, 0,0, 0,  0,0,0,0,1,0),
    v(10,1,0,7,  0,0,0,     0,0,  0,0, 1,  0,0,0,0,0,1),
    v(10,0,0,0,  0,0,0,     1,7,  0,0, 0,  0,0,0,0,1,0)
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_valid_i = 0, alloc_sp_i = 0, wr_valid_i = 0, lk_valid_i = 0;
  logic sp_commit_i = 0, flush_i = 0;
  logic [TAG_W-1:0] alloc_tag_i = '0, wr_tag_i = '0, lk_tag_i = '0, sp_commit_tag_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0, rem_data_i = '0;
  logic stall_o, lk_hit_o, lk_ready_o, rem_req_o, rem_valid_o;
  logic [DATA_W-1:0] lk_data_o, rem_data_o;
  logic [TAG_W-1:0] rem_tag_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  remote_operand_buf #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_remote_operand_buf (
    .clk_i, .rst_ni, .alloc_valid_i, .alloc_sp_i, .alloc_tag_i, .stall_o,
    .wr_valid_i, .wr_tag_i, .wr_data_i, .lk_valid_i, .lk_tag_i,
    .lk_hit_o, .lk_ready_o, .lk_data_o, .rem_req_o, .rem_tag_o, .rem_data_i,
    .rem_valid_o, .rem_data_o, .sp_commit_i, .sp_commit_tag_i, .flush_i
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t x);
    alloc_valid_i = x.av; alloc_sp_i = x.asp; alloc_tag_i = x.atag;
    wr_valid_i = x.wv; wr_tag_i = x.wtag; wr_data_i = {24'h0, x.wd};
    lk_valid_i = x.lv; lk_tag_i = x.ltag;
    sp_commit_i = x.cm; sp_commit_tag_i = x.ctag; flush_i = x.fl;
  endtask

  function automatic logic [63:0] outs();
    return {25'h0, stall_o, lk_hit_o, lk_ready_o, lk_data_o, rem_req_o, rem_valid_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk_i);
    #2;
    chk(outs() == '0 && rem_data_o == '0, "R11", outs(), 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t x;
      logic [63:0] e;
      x = TBL[i];
      @(negedge clk_i);
      apply(x);
      #2;
      e = {25'h0, x.es, x.eh, x.er, 24'h0, x.ed, x.eq, x.erv};
      chk(outs() == e, $sformatf("R%0d row%0d", x.rq, i), outs(), e);
    end

    // R3: request tag and remote data passthrough
    @(negedge clk_i);
    apply('0);
    lk_valid_i = 1; lk_tag_i = 6'd40;
    #2;
    chk(rem_req_o && rem_tag_o == 6'd40, "R3 req", {57'h0, rem_req_o, rem_tag_o}, {57'h0, 1'b1, 6'd40});
    @(negedge clk_i);
    lk_valid_i = 0; rem_data_i = 32'h1234_5678;
    #2;
    chk(rem_valid_o && rem_data_o == 32'h1234_5678, "R3 data", {31'h0, rem_valid_o, rem_data_o},
        {31'h0, 1'b1, 32'h1234_5678});
    @(negedge clk_i);
    rem_data_i = 32'h0;
    #2;
    chk(!rem_valid_o && rem_data_o == '0, "R3 idle", {31'h0, rem_valid_o, rem_data_o}, 64'h0);

    // R11: asynchronous reset empties the committed sp entry
    @(negedge clk_i);
    lk_valid_i = 1; lk_tag_i = 6'd21;
    #2;
    chk(lk_hit_o && lk_data_o == 32'h33, "R11 pre", outs(), {25'h0, 3'b011, 32'h33, 2'b00});
    rst_ni = 1'b0;
    lk_valid_i = 0;
    #1;
    chk(outs() == '0, "R11 async", outs(), 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    lk_valid_i = 1; lk_tag_i = 6'd21;
    #2;
    chk(!lk_hit_o && rem_req_o, "R11 post", outs(), {61'h0, 1'b0, 1'b1, 1'b0});
    @(negedge clk_i);
    apply('0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule